// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the array address for a synchronous burst memory. When an address strobe is accepted, it captures an external address. On later clock edges it steps through the remaining beats of a four-beat burst. Only the two lowest address bits move, and they follow one of two orders. The interleaved order XORs the captured low bits with a beat count. The linear order adds the beat count to them, modulo four. A static select input chooses between the two orders.

There are two load strobes, one for a processor and one for a controller, and they are gated differently by the chip enables:
- The processor strobe is ignored entirely while the master enable is inactive.
- The controller strobe acts whenever the processor strobe is not in effect.

Either strobe can start a burst, or it can deselect the block when the chip enables are not all active. The block raises a valid flag while an address is live.

A burst-advance input moves the counter on to the next beat. While advance is inactive the burst is suspended and the address is held.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `addrValid` is 0 and `arrayAddr` is all zeros.
- R2: A processor strobe (`procStrobeN` low) sampled while `masterEnN` is low, `selHi` is high and `selLoN` is low loads `extAddr`. From the next cycle `arrayAddr` equals that address and `addrValid` is 1. This holds whatever `ctrlStrobeN` is.
- R3: While `masterEnN` is high, a low `procStrobeN` has no effect. The edge behaves as if both strobes were high, so the burst advances or holds according to `advN`.
- R4: A controller strobe (`ctrlStrobeN` low) acts when no processor strobe is in effect on the same edge. It loads `extAddr` when all three enables are active. Otherwise it deselects, which also covers the case where `masterEnN` is high.
- R5: An edge on which a strobe is in effect never advances the burst, even when `advN` is low.
- R6: A strobe in effect while any chip enable is inactive deselects. `addrValid` becomes 0 on the next cycle and `arrayAddr` holds its previous value.
- R7: With `interleave` = 1, beat k (k = 0..3) puts the captured low two bits XOR k on `arrayAddr[1:0]`.
- R8: With `interleave` = 0, beat k puts (captured low two bits + k) mod 4 on `arrayAddr[1:0]`.
- R9: With no strobe in effect and `addrValid` = 1, `advN` low moves the burst to the next beat on the following cycle. `advN` high holds `arrayAddr` unchanged.
- R10: `arrayAddr[ADDR_W-1:2]` changes only on a load.
- R11: After beat 3 the next advance returns to beat 0, so the address wraps to the loaded value.
- R12: While `addrValid` = 0, `advN` low does not change `arrayAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| extAddr | input | ADDR_W | External address captured on a load |
| procStrobeN | input | 1 | Processor address strobe, active low |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| masterEnN | input | 1 | Master chip enable, active low |
| selHi | input | 1 | Secondary chip enable, active high |
| selLoN | input | 1 | Secondary chip enable, active low |
| interleave | input | 1 | Static order select: 1 = XOR order, 0 = linear order |
| arrayAddr | output | ADDR_W | Current array address |
| addrValid | output | 1 | An address is live |

## Verification
A load and an advance can fall on the same edge. Several vectors hold `advN` low on an edge that also carries an accepted strobe. The address seen one cycle later must be the freshly captured value, not one that has already stepped.

The two strobes can also meet. In one case the processor strobe is low while the master enable is high, so it is blocked and the edge must behave as a plain advance. In another, the controller strobe arrives together with that blocked processor strobe and must deselect. Both outcomes are judged on `addrValid` and `arrayAddr` at the following negative clock edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Per-edge commands sent from the control module to the datapath
  typedef struct packed {
    logic load;   // capture external address, restart at beat 0
    logic drop;   // deselect: valid clears, address held
    logic step;   // move to the next beat of the burst
  } seqStrobes_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        procStrobeN,
  input  logic        ctrlStrobeN,
  input  logic        advN,
  input  logic        masterEnN,
  input  logic        selHi,
  input  logic        selLoN,
  output seqStrobes_t strb,
  output logic        addrValid
);

  logic enAll;
  logic procSeen;
  logic ctrlSeen;
  logic anySeen;
  logic validQ;

  // Processor strobe only counts while the master enable is active
  assign enAll    = !masterEnN && selHi && !selLoN;
  assign procSeen = !procStrobeN && !masterEnN;
  assign ctrlSeen = !ctrlStrobeN && !procSeen;
  assign anySeen  = procSeen || ctrlSeen;

  always_comb begin
    strb      = '0;
    strb.load = anySeen && enAll;
    strb.drop = anySeen && !enAll;
    strb.step = !anySeen && !advN && validQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          validQ <= 1'b0;
    else if (strb.load) validQ <= 1'b1;
    else if (strb.drop) validQ <= 1'b0;
  end

  assign addrValid = validQ;

  assert_deselect_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !masterEnN && !selHi) |=> !addrValid);

  assert_blocked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && masterEnN && ctrlStrobeN) |=> (addrValid == $past(addrValid)));

  assert_load_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !masterEnN && selHi && !selLoN) |=> addrValid);

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] arrayAddr
);

  localparam int BEAT_W = $clog2(BURST_LEN);

  logic [ADDR_W-1:0] baseQ;
  logic [BEAT_W-1:0] beatQ;
  logic [BEAT_W-1:0] lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      beatQ <= '0;
    end else if (strb.load) begin
      baseQ <= extAddr;
      beatQ <= '0;
    end else if (strb.step) begin
      beatQ <= beatQ + 1'b1;  // power-of-two length wraps naturally
    end
  end

  always_comb begin
    if (interleave) lowBits = baseQ[BEAT_W-1:0] ^ beatQ;
    else            lowBits = baseQ[BEAT_W-1:0] + beatQ;
  end

  assign arrayAddr = {baseQ[ADDR_W-1:BEAT_W], lowBits};

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (arrayAddr == $past(extAddr)));

  assert_upper_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(arrayAddr[ADDR_W-1:BEAT_W]));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.step && $stable(interleave)) |=> $stable(arrayAddr));

  assert_step_moves_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && $stable(interleave)) |=> (arrayAddr[BEAT_W-1:0] != $past(arrayAddr[BEAT_W-1:0])));

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advN,
  input  logic              masterEnN,
  input  logic              selHi,
  input  logic              selLoN,
  input  logic              interleave,
  output logic [ADDR_W-1:0] arrayAddr,
  output logic              addrValid
);

  seqStrobes_t strb;

  burst_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advN        (advN),
    .masterEnN   (masterEnN),
    .selHi       (selHi),
    .selLoN      (selLoN),
    .strb        (strb),
    .addrValid   (addrValid)
  );

  burst_seq_dp #(
    .ADDR_W    (ADDR_W),
    .BURST_LEN (BURST_LEN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .interleave (interleave),
    .extAddr    (extAddr),
    .arrayAddr  (arrayAddr)
  );

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 18;
  localparam int NVEC       = 18;
  localparam int VW         = 7 + AW + 1 + AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic          procStrobeN = 1'b1, ctrlStrobeN = 1'b1, advN = 1'b1;
  logic          masterEnN = 1'b0, selHi = 1'b1, selLoN = 1'b0, interleave = 1'b1;
  logic [AW-1:0] arrayAddr;
  logic          addrValid;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) uut (
    .clk(clk), .rstN(rstN), .extAddr(extAddr),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advN(advN),
    .masterEnN(masterEnN), .selHi(selHi), .selLoN(selLoN),
    .interleave(interleave), .arrayAddr(arrayAddr), .addrValid(addrValid)
  );

  // {procN, ctrlN, advN, masterEnN, selHi, selLoN, interleave, extAddr, expValid, expAddr}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {7'b0100101, 18'h12345, 1'b1, 18'h12345}, // 0  R2 R5 load, adv ignored
    {7'b1100101, 18'h00000, 1'b1, 18'h12344}, // 1  R7 beat1 01^01
    {7'b1100101, 18'h00000, 1'b1, 18'h12347}, // 2  R7 beat2 01^10
    {7'b1110101, 18'h00000, 1'b1, 18'h12347}, // 3  R9 suspend
    {7'b1100101, 18'h00000, 1'b1, 18'h12346}, // 4  R7 beat3 01^11
    {7'b1100101, 18'h00000, 1'b1, 18'h12345}, // 5  R11 wrap
    {7'b1000100, 18'h2ABCE, 1'b1, 18'h2ABCE}, // 6  R4 R5 controller load, linear
    {7'b1100100, 18'h00000, 1'b1, 18'h2ABCF}, // 7  R8 10+1
    {7'b1100100, 18'h00000, 1'b1, 18'h2ABCC}, // 8  R8 R10 10+2 mod 4
    {7'b1100100, 18'h00000, 1'b1, 18'h2ABCD}, // 9  R8 10+3
    {7'b1100100, 18'h00000, 1'b1, 18'h2ABCE}, // 10 R11 linear wrap
    {7'b0101100, 18'h00003, 1'b1, 18'h2ABCF}, // 11 R3 blocked proc, advances
    {7'b0110000, 18'h00001, 1'b0, 18'h2ABCF}, // 12 R6 deselect, addr held
    {7'b1100100, 18'h00000, 1'b0, 18'h2ABCF}, // 13 R12 no advance when invalid
    {7'b1010101, 18'h3FFFF, 1'b1, 18'h3FFFF}, // 14 R4 controller load
    {7'b1011101, 18'h00005, 1'b0, 18'h3FFFF}, // 15 R4 controller with master off
    {7'b0000101, 18'h00002, 1'b1, 18'h00002}, // 16 R2 both strobes, processor loads
    {7'b0001101, 18'h00004, 1'b0, 18'h00002}  // 17 R3 R4 blocked proc, controller deselects
  };

  localparam string TAG [NVEC] = '{
    "R2/R5", "R7", "R7", "R9", "R7", "R11", "R4/R5", "R8", "R8/R10", "R8",
    "R11", "R3", "R6", "R12", "R4", "R4", "R2", "R3/R4"
  };

  task automatic check(input string req, input logic [AW:0] act, input logic [AW:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advN = 1'b1;
    masterEnN = 1'b0; selHi = 1'b1; selLoN = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {addrValid, arrayAddr}, {1'b0, 18'h00000});
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {addrValid, arrayAddr}, {1'b0, 18'h00000});

    for (int i = 0; i < NVEC; i++) begin
      {procStrobeN, ctrlStrobeN, advN, masterEnN, selHi, selLoN, interleave, extAddr} = VEC[i][VW-1:AW+1];
      @(negedge clk);
      check(TAG[i], {addrValid, arrayAddr}, VEC[i][AW:0]);
    end

    // R8: linear order from low bits 11, then R11 wrap
    idle(); interleave = 1'b0; procStrobeN = 1'b0; extAddr = 18'h01237;
    @(negedge clk);
    check("R2 load 11", {addrValid, arrayAddr}, {1'b1, 18'h01237});
    idle(); advN = 1'b0;
    @(negedge clk);
    check("R8 11+1", {addrValid, arrayAddr}, {1'b1, 18'h01234});
    @(negedge clk);
    check("R8 11+2", {addrValid, arrayAddr}, {1'b1, 18'h01235});

    // R1: reset in the middle of a burst
    rstN = 1'b0;
    #1;
    check("R1 async reset", {addrValid, arrayAddr}, {1'b0, 18'h00000});
    @(negedge clk);
    rstN = 1'b1;
    idle(); advN = 1'b0;
    @(negedge clk);
    check("R12 invalid after reset", {addrValid, arrayAddr}, {1'b0, 18'h00000});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule